// File: doc/BRIEF.md
# Halfword Byte-Swapping DMA Write Path

This block is the write datapath of a DMA channel that sits between a 16-bit peripheral and system memory. The peripheral opens a transfer with a start address, a byte count and a swap flag, then delivers its data as a stream of 16-bit beats. The block forms the memory address by OR-ing the peripheral address with a base-extension value and emits one memory write beat per input beat. Each memory beat carries its own byte address, data, byte strobes and an end-of-chunk marker.

When the swap flag is set, the peripheral's byte order within every halfword is opposite to memory order. The block then forces the address and the byte count to even values and exchanges the two bytes of each halfword. Swapped transfers are also cut into chunks of at most 64 bytes. Unswapped transfers pass through unchanged, keeping the original (possibly odd) address and exact length, and form a single chunk.

Both data interfaces use valid/ready. The input stream advances only in cycles where memory accepts a beat: `in_ready` follows `mem_ready` while a transfer is open, and `mem_valid` follows `in_valid`, so stalls on either side propagate in the same cycle with no buffering. A new chunk therefore starts only in a cycle where the memory side is ready. The beat address, strobes and chunk marker are registered state and hold still while a beat waits. A one-cycle `done` pulse closes every transfer.

Top module: `hws_dma_wr_path`

## Requirements
- R1: The first memory beat address equals `req_addr | base_ext`, both sampled in the cycle the request is accepted, with bit 0 then cleared when the swap flag is set.
- R2: With the swap flag set, bit 0 of the byte count is dropped, so every swapped beat has an even address and both strobe bits set (`mem_strb` = 2'b11).
- R3: With the swap flag set, `mem_data[7:0]` equals `in_data[15:8]` and `mem_data[15:8]` equals `in_data[7:0]` for every beat.
- R4: With the swap flag set, `mem_last` is high on the beat that ends every 64-byte chunk and on the final beat, and on no other beat. No chunk holds more than 32 beats.
- R5: With the swap flag clear, `mem_data` equals `in_data`, the address keeps bit 0, and all bytes of the count are written. On an odd count the final beat has `mem_strb` = 2'b01, carrying its byte on `mem_data[7:0]`. `mem_last` is high only on the final beat.
- R6: Successive beats of one transfer have addresses that rise by 2, across chunk boundaries included.
- R7: `done` is high for exactly the cycle after the last beat is accepted, and `req_ready` is high in that cycle.
- R8: A request whose effective byte count is zero (count 0, or count 1 with swap) raises `done` in the cycle after acceptance and produces no memory beat.
- R9: While a transfer is open, `in_ready` is low whenever `mem_ready` is low, `mem_valid` is low whenever `in_valid` is low, and `mem_addr` holds while a beat is stalled.
- R10: After reset, `req_ready` is high, and `mem_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_ext | input | ADDR_W | Base-extension value OR-ed into the address |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | High when no transfer is open |
| req_addr | input | ADDR_W | Peripheral start byte address |
| req_len | input | LEN_W | Transfer byte count |
| req_swap | input | 1 | Halfword byte swap enable |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | 16 | Input halfword; the byte in bits 7:0 goes first |
| mem_valid | output | 1 | Memory write beat valid |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | ADDR_W | Byte address of the beat's low lane |
| mem_data | output | 16 | Write data, low lane at mem_addr |
| mem_strb | output | 2 | Byte lane enables |
| mem_last | output | 1 | Final beat of a chunk |
| done | output | 1 | One-cycle transfer completion pulse |

## Verification
A memory beat is due in the same cycle as the input beat that feeds it, from the cycle after the request is accepted. `done` is due one cycle after the last accepted beat, or one cycle after acceptance for a zero-length request. The bench drives inputs just after the rising edge and samples at the falling edge, so it sees each handshake before the edge that completes it. When a last beat is seen, the monitor arms a check of `done` and `req_ready` at the next falling edge. The zero-length check samples at the first falling edge after acceptance.

// File: rtl/hws_pkg.sv
package hws_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } hws_state_e;

  localparam int HALF_W = 16;
  localparam int LANE_W = 8;
endpackage

// File: rtl/hws_lane_swap.sv
module hws_lane_swap #(
  parameter int LANE_W = 8
) (
  input  logic              swap_en,
  input  logic [2*LANE_W-1:0] din,
  output logic [2*LANE_W-1:0] dout
);
  logic [LANE_W-1:0] lo_lane, hi_lane;

  assign lo_lane = din[LANE_W-1:0];
  assign hi_lane = din[2*LANE_W-1:LANE_W];

  // exchange the two lanes of the halfword only in swap mode
  assign dout = swap_en ? {lo_lane, hi_lane} : din;
endmodule

// File: rtl/hws_req_front.sv
module hws_req_front #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic [ADDR_W-1:0] periph_addr,
  input  logic [ADDR_W-1:0] base_ext,
  input  logic [LEN_W-1:0]  periph_len,
  input  logic              swap_en,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [LEN_W-1:0]  eff_len
);
  logic [ADDR_W-1:0] merged;

  assign merged = periph_addr | base_ext;

  // swap mode works on whole halfwords: drop the odd address and count bits
  assign eff_addr = {merged[ADDR_W-1:1], merged[0] & ~swap_en};
  assign eff_len  = {periph_len[LEN_W-1:1], periph_len[0] & ~swap_en};
endmodule

// File: rtl/hws_chunk_ctl.sv
module hws_chunk_ctl
  import hws_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int CHUNK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  input  logic              start_swap,
  input  logic              beat,
  output logic              busy,
  output logic              swap_mode,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [1:0]        strb,
  output logic              last,
  output logic              done
);
  localparam logic [LEN_W-1:0] CHUNK_L  = LEN_W'(CHUNK_BYTES);
  localparam logic [LEN_W-1:0] TWO_L    = LEN_W'(2);
  localparam int BEATS_PER_CHUNK        = CHUNK_BYTES / 2;
  localparam int BC_W                   = $clog2(BEATS_PER_CHUNK + 1);

  hws_state_e        st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  remain_q, chunk_q;
  logic              swap_q, done_q;
  logic [LEN_W-1:0]  step, remain_nx;
  logic [BC_W-1:0]   bc_q;

  function automatic logic [LEN_W-1:0] chunk_of(input logic [LEN_W-1:0] n,
                                                input logic sw);
    if (sw && (n > CHUNK_L)) return CHUNK_L;
    return n;
  endfunction

  assign step      = (remain_q >= TWO_L) ? TWO_L : LEN_W'(1);
  assign remain_nx = remain_q - step;

  assign busy      = (st_q == ST_RUN);
  assign swap_mode = swap_q;
  assign cur_addr  = addr_q;
  assign strb      = (remain_q >= TWO_L) ? 2'b11 : 2'b01;
  assign last      = (chunk_q <= TWO_L);
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      remain_q <= '0;
      chunk_q  <= '0;
      swap_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            if (start_len == '0) begin
              done_q <= 1'b1;
            end else begin
              st_q     <= ST_RUN;
              addr_q   <= start_addr;
              remain_q <= start_len;
              chunk_q  <= chunk_of(start_len, start_swap);
              swap_q   <= start_swap;
            end
          end
        end
        ST_RUN: begin
          if (beat) begin
            addr_q   <= addr_q + ADDR_W'(step);
            remain_q <= remain_nx;
            if (last) begin
              if (remain_nx == '0) begin
                st_q   <= ST_IDLE;
                done_q <= 1'b1;
              end else begin
                chunk_q <= chunk_of(remain_nx, swap_q);
              end
            end else begin
              chunk_q <= chunk_q - step;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // beats issued in the current chunk, kept for the chunk-size check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_q <= '0;
    end else if (start || (beat && last)) begin
      bc_q <= '0;
    end else if (beat) begin
      bc_q <= bc_q + BC_W'(1);
    end
  end

  p_even_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && swap_q) |-> (addr_q[0] == 1'b0 && strb == 2'b11));

  p_chunk_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && swap_q) |-> (bc_q < BC_W'(BEATS_PER_CHUNK)));

  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !last) |=> (addr_q == $past(addr_q) + ADDR_W'(2)));

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (st_q == ST_IDLE));
endmodule

// File: rtl/hws_dma_wr_path.sv
module hws_dma_wr_path
  import hws_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int CHUNK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_ext,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_swap,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [HALF_W-1:0] in_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [HALF_W-1:0] mem_data,
  output logic [1:0]        mem_strb,
  output logic              mem_last,
  output logic              done
);
  logic              busy, swap_mode, accept, beat;
  logic [ADDR_W-1:0] eff_addr;
  logic [LEN_W-1:0]  eff_len;

  assign req_ready = ~busy;
  assign accept    = req_valid & req_ready;
  assign mem_valid = busy & in_valid;
  assign in_ready  = busy & mem_ready;
  assign beat      = mem_valid & mem_ready;

  hws_req_front #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_front (
    .periph_addr (req_addr),
    .base_ext    (base_ext),
    .periph_len  (req_len),
    .swap_en     (req_swap),
    .eff_addr    (eff_addr),
    .eff_len     (eff_len)
  );

  hws_chunk_ctl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CHUNK_BYTES(CHUNK_BYTES)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_addr (eff_addr),
    .start_len  (eff_len),
    .start_swap (req_swap),
    .beat       (beat),
    .busy       (busy),
    .swap_mode  (swap_mode),
    .cur_addr   (mem_addr),
    .strb       (mem_strb),
    .last       (mem_last),
    .done       (done)
  );

  hws_lane_swap #(.LANE_W(LANE_W)) u_swap (
    .swap_en (swap_mode),
    .din     (in_data),
    .dout    (mem_data)
  );

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> $stable(mem_addr));

  p_no_input_without_mem_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ready) |-> !in_ready);
endmodule

// File: tb/hws_dma_wr_path_tb_top.sv
module hws_dma_wr_path_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] base_ext = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic          req_swap = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [15:0]   in_data = '0;
  logic          mem_valid;
  logic          mem_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_data;
  logic [1:0]    mem_strb;
  logic          mem_last;
  logic          done;

  int checks = 0;
  int failures = 0;
  int done_cnt = 0;
  int xfers = 0;
  int ready_pct = 100;
  int gap_pct = 0;
  bit arm_done = 1'b0;
  bit finished = 1'b0;

  logic [AW-1:0] q_addr[$];
  logic [15:0]   q_data[$];
  logic [1:0]    q_strb[$];
  logic          q_last[$];
  logic          q_end[$];
  string         q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hws_dma_wr_path dut_i (
    .clk(clk), .rst_n(rst_n), .base_ext(base_ext),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_swap(req_swap),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_strb(mem_strb), .mem_last(mem_last),
    .done(done)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // memory-side back-pressure
  initial begin
    forever begin
      @(posedge clk);
      #1;
      mem_ready = ($urandom_range(0, 99) < ready_pct);
    end
  end

  // monitor: pops the expected beats as the design produces them
  always @(negedge clk) begin
    if (rst_n) begin
      if (arm_done) begin
        check(done && req_ready, "R7 done/req_ready after last beat",
              {req_ready, done}, 2'b11);
        arm_done = 1'b0;
      end
      if (done) done_cnt++;
      if (mem_valid && !in_valid)
        check(1'b0, "R9 mem_valid without in_valid", mem_valid, 0);
      if (mem_valid && !mem_ready)
        check(!in_ready, "R9 in_ready while memory stalls", in_ready, 0);
      if (mem_valid && mem_ready) begin
        if (q_addr.size() == 0) begin
          check(1'b0, "R8 unexpected memory beat", mem_addr, 0);
        end else begin
          logic [AW-1:0] ea;
          logic [15:0]   ed, md;
          logic [1:0]    es;
          logic          el, ee;
          string         tg;
          ea = q_addr.pop_front();
          ed = q_data.pop_front();
          es = q_strb.pop_front();
          el = q_last.pop_front();
          ee = q_end.pop_front();
          tg = q_tag.pop_front();
          md = (es == 2'b01) ? {8'h00, mem_data[7:0]} : mem_data;
          check(mem_addr == ea, "R1/R6 beat address", mem_addr, ea);
          check(md == ed, {tg, " beat data"}, md, ed);
          check(mem_strb == es, "R2/R5 strobes", mem_strb, es);
          check(mem_last == el, "R4/R5 chunk end marker", mem_last, el);
          if (ee) arm_done = 1'b1;
        end
      end
    end
  end

  task automatic run_xfer(input logic [AW-1:0] a, input logic [LW-1:0] l,
                          input logic sw, input logic [AW-1:0] base);
    logic [AW-1:0] ea;
    int            el, remain, chunk, nb;
    logic [15:0]   din[$];
    int            c0;
    bit            hs;
    logic [7:0]    seed;
    ea = a | base;
    el = int'(l);
    if (sw) begin
      ea[0] = 1'b0;
      el = el & ~1;
    end
    seed = 8'($urandom_range(0, 255));
    remain = el;
    chunk = (sw && remain > 64) ? 64 : remain;
    for (int k = 0; remain > 0; k++) begin
      logic [15:0] d;
      logic        lst;
      d = {8'(seed + 8'(2*k+1)), 8'(seed + 8'(2*k))};
      din.push_back(d);
      nb = (remain >= 2) ? 2 : 1;
      lst = (chunk <= 2);
      q_addr.push_back(ea);
      q_data.push_back(sw ? {d[7:0], d[15:8]} : (nb == 2 ? d : {8'h00, d[7:0]}));
      q_strb.push_back(nb == 2 ? 2'b11 : 2'b01);
      q_last.push_back(lst);
      q_end.push_back(remain == nb);
      q_tag.push_back(sw ? "R3" : "R5");
      remain -= nb;
      ea += AW'(nb);
      chunk = lst ? ((sw && remain > 64) ? 64 : remain) : chunk - nb;
    end
    xfers++;
    c0 = done_cnt;
    base_ext = base; req_addr = a; req_len = l; req_swap = sw; req_valid = 1'b1;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    if (el == 0) begin
      @(negedge clk);
      check(done == 1'b1, "R8 zero-length done pulse", done, 1);
      check(mem_valid == 1'b0, "R8 zero-length has no beat", mem_valid, 0);
      @(posedge clk);
      #1;
    end else begin
      foreach (din[i]) begin
        while ($urandom_range(0, 99) < gap_pct) begin
          @(posedge clk);
          #1;
        end
        in_valid = 1'b1;
        in_data = din[i];
        do begin
          @(negedge clk);
          hs = in_ready;
          @(posedge clk);
          #1;
        end while (!hs);
        in_valid = 1'b0;
      end
      while (done_cnt == c0) @(negedge clk);
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    #1;
    @(negedge clk);
    check(req_ready == 1'b1, "R10 reset req_ready", req_ready, 1);
    check(mem_valid == 1'b0, "R10 reset mem_valid", mem_valid, 0);
    check(done == 1'b0, "R10 reset done", done, 0);
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(posedge clk);
    #1;

    run_xfer(32'h0000_0100, 16'd8, 1'b1, 32'h8000_0000);     // R1 R3 aligned swap
    run_xfer(32'h0000_0033, 16'd7, 1'b1, 32'h0000_4400);     // R2 odd bits dropped
    run_xfer(32'h0000_0035, 16'd5, 1'b0, 32'h0000_1000);     // R5 odd addr, odd count
    run_xfer(32'h0000_0200, 16'd130, 1'b1, 32'h0100_0000);   // R4 chunks 64/64/2
    run_xfer(32'h0000_0301, 16'd1, 1'b1, 32'h0);             // R8 becomes zero
    run_xfer(32'h0000_0400, 16'd0, 1'b0, 32'h0);             // R8 zero count
    run_xfer(32'h0000_0500, 16'd100, 1'b0, 32'h0002_0000);   // R5 one chunk
    ready_pct = 40;
    gap_pct = 30;
    run_xfer(32'h0000_0600, 16'd200, 1'b1, 32'h0);           // R9 stalls, R4 chunks
    for (int n = 0; n < 24; n++) begin
      run_xfer(32'($urandom_range(0, 4095)), 16'($urandom_range(0, 180)),
               1'($urandom_range(0, 1)), {16'($urandom_range(0, 255)), 16'h0000});
    end
    repeat (3) @(posedge clk);
    check(done_cnt == xfers, "R7 one done pulse per transfer", done_cnt, xfers);
    check(q_addr.size() == 0, "R5 all expected beats produced", q_addr.size(), 0);
    finish_up();
  end
endmodule